// File: doc/BRIEF.md
# Fractional Line-Interrupt Delay Scheduler

This block works out, in whole CPU cycles, how long a line interrupt must wait before it fires. One scan line lasts a non-integer number of CPU cycles (488.5). The block keeps the running time in a fixed-point accumulator with a four-bit fraction, so the half cycle is not lost. Each time the interrupt is armed, it adds the programmed number of lines times the line period. It then emits the whole-cycle part as a delay with a one-cycle valid pulse and keeps only the fractional residue for the next arming.

At the start of vertical blanking, when the mode flag is clear, the accumulator is preset to a small negative bias of −1.5 cycles. This makes the next line interrupt land just ahead of the vertical interrupt. With the mode flag clear, arming requests made during vertical blanking are dropped. With the flag set, line interrupts run through blanking and the vblank strobe is ignored. Delivering the interrupt and queuing the event belong to the surrounding logic.

Top module: `line_irq_sched`

## Requirements
- R1: After reset, `hint_valid` and `hint_delay` are 0 and the accumulator is empty. The first arming with reload 0 yields delay 488.
- R2: An arming that is accepted raises `hint_valid` for exactly the following clock cycle, together with the new `hint_delay`. A single arm strobe gives a single-cycle pulse.
- R3: An accepted arming adds (reload + 1) × 7816 to the accumulator, where 7816 is 488.5 in Q4 and reload is `line_reload` sampled in the arming cycle. The delay is the sum shifted right by 4. For example, a residue of 8 with reload 2 gives 1466.
- R4: After each accepted arming, only the low four bits of the sum stay in the accumulator. Back-to-back armings with reload 0 starting from an empty accumulator give 488, then 489, then 488.
- R5: The largest reload, 255, from an empty accumulator gives delay 125056 and leaves a residue of 0.
- R6: A `vblank_start` strobe while `hint_in_vblank` is 0 presets the accumulator to −24 (−1.5 cycles), discarding any residue. A following arming with reload 0 gives 487.
- R7: While `hint_in_vblank` is 1, `vblank_start` has no effect and the residue is kept.
- R8: While `hint_in_vblank` is 0 and `in_vblank` is 1, an arm strobe produces no pulse and leaves the accumulator unchanged.
- R9: While `hint_in_vblank` is 1, an arming is accepted even when `in_vblank` is 1.
- R10: When `vblank_start` and an accepted arming occur in the same cycle, the preset is applied before the addition. With reload 0 this gives 487.
- R11: Between pulses, `hint_delay` holds the last emitted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_reload | input | 8 | Lines between interrupts minus one |
| hint_in_vblank | input | 1 | 1: line interrupts also run during vertical blanking |
| vblank_start | input | 1 | Single-cycle strobe at the start of vertical blanking |
| in_vblank | input | 1 | Level, high during vertical blanking |
| hint_arm | input | 1 | Strobe requesting the next interrupt delay |
| hint_delay | output | 18 | Delay to the next interrupt in whole CPU cycles |
| hint_valid | output | 1 | One-cycle pulse marking a new `hint_delay` |

## Verification
The accumulator is never visible directly. A wrong residue only shows up one arming later, as a delay that is off by one in the alternating 488/489 pattern, or as a missing or extra cycle after a vblank preset. The bench therefore always follows a preset, a suppressed arming or an ignored strobe with another arming, and compares that delay. Errors in accepting or dropping an arming show up in the very next cycle as a missing or extra `hint_valid` pulse.

// File: rtl/line_irq_sched.sv
module line_irq_sched #(
  parameter int RELOAD_W  = 8,
  parameter int FRAC_W    = 4,
  parameter int ACC_W     = 22,
  parameter int PERIOD_Q4 = 7816,
  parameter int VB_BIAS   = 24,
  localparam int DLY_W    = ACC_W - FRAC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] line_reload,
  input  logic                hint_in_vblank,
  input  logic                vblank_start,
  input  logic                in_vblank,
  input  logic                hint_arm,
  output logic [DLY_W-1:0]    hint_delay,
  output logic                hint_valid
);

  localparam logic [ACC_W-1:0] BIAS_Q = ACC_W'(-VB_BIAS);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] sum;
  logic             fire;

  assign base = (vblank_start && !hint_in_vblank) ? BIAS_Q : acc;
  assign step = ACC_W'({1'b0, line_reload} + 1'b1) * ACC_W'(PERIOD_Q4);
  assign sum  = base + step;
  assign fire = hint_arm && (hint_in_vblank || !in_vblank);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      hint_delay <= '0;
      hint_valid <= 1'b0;
    end else begin
      hint_valid <= fire;
      if (fire) begin
        hint_delay <= sum[ACC_W-1:FRAC_W];
        acc        <= {{DLY_W{1'b0}}, sum[FRAC_W-1:0]};
      end else begin
        acc <= base;
      end
    end
  end

endmodule

module line_irq_sched_chk #(
  parameter int RELOAD_W = 8,
  parameter int DLY_W    = 18
) (
  input logic                clk,
  input logic                rst,
  input logic [RELOAD_W-1:0] line_reload,
  input logic                hint_in_vblank,
  input logic                vblank_start,
  input logic                in_vblank,
  input logic                hint_arm,
  input logic [DLY_W-1:0]    hint_delay,
  input logic                hint_valid
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !hint_valid); // R1

  AST_PULSE_FOLLOWS_ARM: assert property (@(posedge clk) disable iff (rst)
    hint_valid |-> $past(hint_arm)); // R2

  AST_ARM_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (hint_arm && (hint_in_vblank || !in_vblank)) |=> hint_valid); // R9

  AST_ARM_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (hint_arm && !hint_in_vblank && in_vblank) |=> !hint_valid); // R8

  AST_DELAY_HELD: assert property (@(posedge clk) disable iff (rst)
    !hint_arm |=> $stable(hint_delay)); // R11

endmodule

bind line_irq_sched line_irq_sched_chk #(.RELOAD_W(RELOAD_W), .DLY_W(DLY_W)) chk_i (
  .clk(clk), .rst(rst), .line_reload(line_reload), .hint_in_vblank(hint_in_vblank),
  .vblank_start(vblank_start), .in_vblank(in_vblank), .hint_arm(hint_arm),
  .hint_delay(hint_delay), .hint_valid(hint_valid)
);

// File: tb/line_irq_sched_tb.sv
module line_irq_sched_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  line_reload = '0;
  logic        hint_in_vblank = 1'b0;
  logic        vblank_start = 1'b0;
  logic        in_vblank = 1'b0;
  logic        hint_arm = 1'b0;
  logic [17:0] hint_delay;
  logic        hint_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_irq_sched dut_i (
    .clk(clk), .rst(rst), .line_reload(line_reload), .hint_in_vblank(hint_in_vblank),
    .vblank_start(vblank_start), .in_vblank(in_vblank), .hint_arm(hint_arm),
    .hint_delay(hint_delay), .hint_valid(hint_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm_expect(input logic [7:0] rl, input int exp, input string req);
    @(negedge clk);
    line_reload = rl;
    hint_arm = 1'b1;
    @(negedge clk);
    hint_arm = 1'b0;
    line_reload = ~rl;
    check({req, " valid"}, int'(hint_valid), 1);
    check({req, " delay"}, int'(hint_delay), exp);
    @(negedge clk);
    check("R2 pulse ends", int'(hint_valid), 0);
  endtask

  task automatic vb_strobe();
    @(negedge clk);
    vblank_start = 1'b1;
    @(negedge clk);
    vblank_start = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 valid after reset", int'(hint_valid), 0);
    check("R1 delay after reset", int'(hint_delay), 0);
    arm_expect(8'd0, 488, "R1 first arming");
  endtask

  task automatic t_carry();
    arm_expect(8'd0, 489, "R4 residue carried");
    arm_expect(8'd0, 488, "R4 residue cleared");
    arm_expect(8'd2, 1466, "R3 reload 2 with residue");
  endtask

  task automatic t_max();
    arm_expect(8'd255, 125056, "R5 max reload");
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    check("R11 delay held", int'(hint_delay), 125056);
    check("R11 no pulse idle", int'(hint_valid), 0);
  endtask

  task automatic t_preset();
    hint_in_vblank = 1'b0;
    in_vblank = 1'b1;
    vb_strobe();
    in_vblank = 1'b0;
    arm_expect(8'd0, 487, "R6 vblank bias");
  endtask

  task automatic t_suppress();
    arm_expect(8'd0, 488, "R8 setup");
    @(negedge clk);
    in_vblank = 1'b1;
    line_reload = 8'd5;
    hint_arm = 1'b1;
    @(negedge clk);
    hint_arm = 1'b0;
    check("R8 no pulse in vblank", int'(hint_valid), 0);
    check("R8 delay unchanged", int'(hint_delay), 488);
    in_vblank = 1'b0;
    arm_expect(8'd0, 489, "R8 accumulator untouched");
  endtask

  task automatic t_mode_on();
    hint_in_vblank = 1'b1;
    arm_expect(8'd0, 488, "R7 setup");
    in_vblank = 1'b1;
    vb_strobe();
    in_vblank = 1'b0;
    arm_expect(8'd0, 489, "R7 strobe ignored");
    in_vblank = 1'b1;
    arm_expect(8'd1, 977, "R9 arming in vblank");
    in_vblank = 1'b0;
  endtask

  task automatic t_simul();
    hint_in_vblank = 1'b0;
    arm_expect(8'd0, 488, "R10 setup");
    @(negedge clk);
    line_reload = 8'd0;
    vblank_start = 1'b1;
    hint_arm = 1'b1;
    @(negedge clk);
    vblank_start = 1'b0;
    hint_arm = 1'b0;
    check("R10 valid", int'(hint_valid), 1);
    check("R10 preset before add", int'(hint_delay), 487);
  endtask

  initial begin
    t_reset();
    t_carry();
    t_max();
    t_hold();
    t_preset();
    t_suppress();
    t_mode_on();
    t_simul();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule